// File: doc/BRIEF.md
# I2C Master Bus Timing Generator

This block produces the clock and data line waveforms of an I2C master at the bit level. A controller above it issues one command at a time: a start condition, a single data bit or a stop condition. The block then drives the open-drain enables for SCL and SDA with programmed pulse widths and reports the end of each command with a one-cycle strobe. Byte framing, acknowledge handling, arbitration and slave clock stretching are left to the surrounding logic.

All timing is counted in 50 ns time-base ticks. The block counts only the clock cycles on which `tick` is high, so it runs from a 20 MHz clock with `tick` tied high, or from a faster clock with a tick divider. The SCL high width, SCL low width and a 2-bit SDA delay code are sampled when a command is accepted. Within every SCL low phase, SDA moves to its new level a coded 7 to 10 ticks (350 to 500 ns) after SCL falls. That delay is clipped so that SDA always settles at least one tick before SCL is released. An enable of 1 pulls a line low; 0 releases it.

Top module: `i2cm_timing_gen`

## Requirements
- R1: After reset `scl_oe`=0, `sda_oe`=0, `bit_done`=0 and `cmd_ready`=1.
- R2: START (`cmd_op`=2'b01) on a free bus (`scl_oe`=0) sets `sda_oe` on the accepting edge. It keeps SCL released for H ticks, then sets `scl_oe` and pulses `bit_done` on that edge.
- R3: BIT (`cmd_op`=2'b11) on a held bus (`scl_oe`=1) keeps SCL low for L ticks, releases it for H ticks, then pulls it low again with `bit_done` on that edge.
- R4: In each SCL low phase, SDA takes its target level D ticks after the phase starts, where D = min(7 + code, L - 1) and code is `cfg_sda_dly` (0..3). For BIT the target is `sda_oe` = NOT `cmd_bit`.
- R5: SDA never changes while SCL is released before and after, except for the start pull-down (R2, R7) and the stop release (R6).
- R6: STOP (`cmd_op`=2'b10) on a held bus pulls SDA low at D ticks, releases SCL at L ticks and releases SDA at L+H ticks with `bit_done`, which leaves the bus free.
- R7: START on a held bus releases SDA at D ticks and releases SCL at L ticks. At L+H ticks it pulls SDA low, and at L+2H ticks it pulls SCL low with `bit_done`.
- R8: H is `cfg_scl_high`, with 0 taken as 1. L is `cfg_scl_low`, with values below 2 taken as 2.
- R9: Configuration inputs are sampled only on the accepting edge. Changes during a command do not alter its timing.
- R10: BIT or STOP issued on a free bus is dropped. No line changes, no `bit_done` is given, and `cmd_ready` stays 1.
- R11: Phase durations count only the cycles on which `tick` is high. SCL changes only on an edge where `tick` was high.
- R12: `bit_done` lasts one cycle. `cmd_ready` is 1 only between commands, and is 1 again in the cycle `bit_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 50 ns time-base enable |
| cfg_scl_high | input | 8 | SCL high width in ticks |
| cfg_scl_low | input | 8 | SCL low width in ticks |
| cfg_sda_dly | input | 2 | SDA delay code, 7+code ticks after SCL falls |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 01 start, 10 stop, 11 bit, 00 none |
| cmd_bit | input | 1 | Data bit for BIT |
| cmd_ready | output | 1 | Idle and able to accept a command |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bit_done | output | 1 | One-cycle end-of-command strobe |

## Verification
The assertions check on every cycle that SDA stays still while SCL is high except at start and stop, and that SCL moves only on tick edges. They also check that the low phase counter stays inside the low width, that the clipped SDA delay stays inside the low phase, and that `bit_done` is a single-cycle pulse seen only with the sequencer idle. Only the bench scenarios can show the exact tick counts of each edge for every command. The same holds for the bit-to-SDA mapping, the repeated start sequence, the dropping of illegal commands, and the immunity of a running command to configuration changes, since these depend on sequences across whole commands.

// File: rtl/i2cm_tg_pkg.sv
package i2cm_tg_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_BIT   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2,
    PH_SHOLD = 2'd3
  } phase_e;
endpackage

// File: rtl/i2cm_tg_cfg.sv
module i2cm_tg_cfg #(
  parameter int TW       = 8,
  parameter int DW       = 2,
  parameter int DLY_BASE = 7,
  parameter int HI_MIN   = 1,
  parameter int LO_MIN   = 2,
  parameter int HI_RST   = 130,
  parameter int LO_RST   = 130
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] raw_hi,
  input  logic [TW-1:0] raw_lo,
  input  logic [DW-1:0] raw_dly,
  output logic [TW-1:0] hi_q,
  output logic [TW-1:0] lo_q,
  output logic [TW-1:0] dly_q
);
  localparam int XW = TW + 1;
  localparam logic [XW-1:0] HI_FLOOR = XW'(HI_MIN);
  localparam logic [XW-1:0] LO_FLOOR = XW'(LO_MIN);
  localparam logic [XW-1:0] BASE_X   = XW'(DLY_BASE);

  logic [XW-1:0] hi_x, lo_x, dly_x, lim_x, dly_c;

  always_comb begin
    hi_x  = ({1'b0, raw_hi} < HI_FLOOR) ? HI_FLOOR : {1'b0, raw_hi};
    lo_x  = ({1'b0, raw_lo} < LO_FLOOR) ? LO_FLOOR : {1'b0, raw_lo};
    dly_x = BASE_X + XW'(raw_dly);
    lim_x = lo_x - XW'(1);
    dly_c = (dly_x > lim_x) ? lim_x : dly_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= TW'(HI_RST);
      lo_q  <= TW'(LO_RST);
      dly_q <= TW'(DLY_BASE);
    end else if (load) begin
      hi_q  <= hi_x[TW-1:0];
      lo_q  <= lo_x[TW-1:0];
      dly_q <= dly_c[TW-1:0];
    end
  end

  a_r4_dly_window: assert property (@(posedge clk) disable iff (rst)
    (dly_q >= TW'(1)) && (dly_q < lo_q));
  a_r8_floor: assert property (@(posedge clk) disable iff (rst)
    (hi_q >= TW'(HI_MIN)) && (lo_q >= TW'(LO_MIN)));
endmodule

// File: rtl/i2cm_tg_ticker.sv
module i2cm_tg_ticker #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] len,
  input  logic [CW-1:0] mark,
  output logic [CW-1:0] elapsed,
  output logic          last,
  output logic          hit
);
  logic [CW:0] nxt;

  always_comb begin
    nxt  = {1'b0, elapsed} + (CW+1)'(1);
    last = tick && (nxt == {1'b0, len});
    hit  = tick && (nxt == {1'b0, mark});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) elapsed <= '0;
    else if (tick)  elapsed <= nxt[CW-1:0];
  end
endmodule

// File: rtl/i2cm_tg_seq.sv
module i2cm_tg_seq
  import i2cm_tg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic   cmd_bit,
  input  logic   last,
  input  logic   hit,
  output phase_e phase,
  output logic   accept,
  output logic   ready,
  output logic   scl_oe,
  output logic   sda_oe,
  output logic   done
);
  op_e  op_in, op_q;
  logic legal;
  logic tgt_q;

  always_comb begin
    op_in  = op_e'(cmd_op);
    ready  = (phase == PH_WAIT);
    legal  = (op_in == OP_START) ||
             (scl_oe && ((op_in == OP_STOP) || (op_in == OP_BIT)));
    accept = ready && cmd_valid && legal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_WAIT;
      op_q   <= OP_NONE;
      tgt_q  <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_WAIT: begin
          if (accept) begin
            op_q <= op_in;
            if ((op_in == OP_START) && !scl_oe) begin
              sda_oe <= 1'b1;
              phase  <= PH_SHOLD;
            end else begin
              if (op_in == OP_BIT)       tgt_q <= !cmd_bit;
              else if (op_in == OP_STOP) tgt_q <= 1'b1;
              else                       tgt_q <= 1'b0;
              phase <= PH_LOW;
            end
          end
        end
        PH_LOW: begin
          if (hit) sda_oe <= tgt_q;
          if (last) begin
            scl_oe <= 1'b0;
            phase  <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (last) begin
            if (op_q == OP_START) begin
              sda_oe <= 1'b1;
              phase  <= PH_SHOLD;
            end else begin
              if (op_q == OP_STOP) sda_oe <= 1'b0;
              else                 scl_oe <= 1'b1;
              done  <= 1'b1;
              phase <= PH_WAIT;
            end
          end
        end
        PH_SHOLD: begin
          if (last) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            phase  <= PH_WAIT;
          end
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  a_r5_sda_pull_high: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (phase == PH_SHOLD));
  a_r5_sda_free_high: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> done);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == PH_WAIT));
  a_r10_drop: assert property (@(posedge clk) disable iff (rst)
    (ready && cmd_valid && !scl_oe && (cmd_op == 2'b10 || cmd_op == 2'b11))
    |=> (phase == PH_WAIT && !scl_oe && !sda_oe && !done));
endmodule

// File: rtl/i2cm_timing_gen.sv
module i2cm_timing_gen
  import i2cm_tg_pkg::*;
#(
  parameter int TW       = 8,
  parameter int DW       = 2,
  parameter int DLY_BASE = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [TW-1:0] cfg_scl_high,
  input  logic [TW-1:0] cfg_scl_low,
  input  logic [DW-1:0] cfg_sda_dly,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  output logic          cmd_ready,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          bit_done
);
  phase_e        phase;
  logic          accept, last, hit, clr;
  logic [TW-1:0] hi_q, lo_q, dly_q, len, elapsed;

  i2cm_tg_cfg #(.TW(TW), .DW(DW), .DLY_BASE(DLY_BASE)) u_cfg (
    .clk(clk), .rst(rst), .load(accept),
    .raw_hi(cfg_scl_high), .raw_lo(cfg_scl_low), .raw_dly(cfg_sda_dly),
    .hi_q(hi_q), .lo_q(lo_q), .dly_q(dly_q)
  );

  always_comb begin
    len = (phase == PH_LOW) ? lo_q : hi_q;
    clr = (phase == PH_WAIT) || last;
  end

  i2cm_tg_ticker #(.CW(TW)) u_tick (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick),
    .len(len), .mark(dly_q), .elapsed(elapsed), .last(last), .hit(hit)
  );

  i2cm_tg_seq u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .last(last), .hit(hit), .phase(phase),
    .accept(accept), .ready(cmd_ready), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(bit_done)
  );

  a_r3_low_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW) |-> (elapsed < lo_q));
  a_r11_scl_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe) |-> $past(tick));
endmodule

// File: tb/i2cm_timing_gen_test.sv
module i2cm_timing_gen_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [7:0] cfg_hi = 8'h82, cfg_lo = 8'h82;
  logic [1:0] cfg_dly = 2'd0;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready, scl_oe, sda_oe, bit_done;

  i2cm_timing_gen uut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_scl_high(cfg_hi),
    .cfg_scl_low(cfg_lo), .cfg_sda_dly(cfg_dly), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .bit_done(bit_done)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int tick_mode = 0;
  bit scramble = 0;
  bit m_held = 0, m_sda = 0;
  int cur_hi = 3, cur_lo = 12, cur_code = 0;

  always @(posedge clk) begin
    #1;
    tick = (tick_mode == 0) ? 1'b1 : (($urandom % 3) == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_hi(int h); return (h == 0) ? 1 : h; endfunction
  function automatic int eff_lo(int l); return (l < 2) ? 2 : l; endfunction
  function automatic int eff_dly(int l, int c);
    int d = 7 + c;
    int m = eff_lo(l) - 1;
    return (d > m) ? m : d;
  endfunction

  // op: 1 START, 2 STOP, 3 BIT
  task automatic run_cmd(input int op, input bit b, input string req_in);
    int scl_t[4], sda_t[4], esc[4], esd[4];
    int ns = 0, nd = 0, nes = 0, ned = 0, cnt = 0, done_t = -1, edone = 0;
    int guard = 0, viol = 0;
    int he = eff_hi(cur_hi), le = eff_lo(cur_lo), de = eff_dly(cur_lo, cur_code);
    bit pscl, psda;
    string req = req_in;
    if (scramble) req = {req, " R9"};
    if (tick_mode != 0) req = {req, " R11"};
    if (op == 1 && !m_held) begin
      esd[0] = 0; ned = 1; esc[0] = he; nes = 1; edone = he;
      m_held = 1; m_sda = 1;
    end else if (op == 1) begin
      if (m_sda) begin esd[ned] = de; ned++; end
      esd[ned] = le + he; ned++;
      esc[0] = le; esc[1] = le + 2*he; nes = 2; edone = le + 2*he;
      m_sda = 1;
    end else if (op == 3) begin
      if (m_sda == b) begin esd[0] = de; ned = 1; end
      esc[0] = le; esc[1] = le + he; nes = 2; edone = le + he;
      m_sda = !b;
    end else begin
      if (!m_sda) begin esd[ned] = de; ned++; end
      esd[ned] = le + he; ned++;
      esc[0] = le; nes = 1; edone = le + he;
      m_held = 0; m_sda = 0;
    end
    @(posedge clk); #1;
    chk(cmd_ready === 1'b1, "R12 ready before command", cmd_ready, 1);
    cfg_hi = 8'(cur_hi); cfg_lo = 8'(cur_lo); cfg_dly = 2'(cur_code);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = b;
    pscl = scl_oe; psda = sda_oe;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 2'd0;
    if (scramble) begin
      cfg_hi = 8'($urandom); cfg_lo = 8'($urandom); cfg_dly = 2'($urandom);
    end
    while (done_t < 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (sda_oe !== psda) begin
        if (!pscl && !scl_oe &&
            !((op == 1 && sda_oe) || (op == 2 && !sda_oe))) viol++;
        if (nd < 4) sda_t[nd] = cnt;
        nd++; psda = sda_oe;
      end
      if (scl_oe !== pscl) begin
        if (ns < 4) scl_t[ns] = cnt;
        ns++; pscl = scl_oe;
      end
      if (bit_done) done_t = cnt;
      if (tick) cnt++;
    end
    chk(done_t == edone, {req, " done tick"}, done_t, edone);
    chk(cmd_ready === 1'b1, "R12 ready with done", cmd_ready, 1);
    chk(viol == 0, "R5 sda moved with scl high", viol, 0);
    chk(ns == nes, {req, " scl edge count"}, ns, nes);
    for (int i = 0; i < nes && i < ns; i++)
      chk(scl_t[i] == esc[i], {req, " scl edge tick"}, scl_t[i], esc[i]);
    chk(nd == ned, {req, " R4 sda edge count"}, nd, ned);
    for (int i = 0; i < ned && i < nd; i++)
      chk(sda_t[i] == esd[i], {req, " R4 sda edge tick"}, sda_t[i], esd[i]);
    @(negedge clk);
    chk(bit_done === 1'b0, "R12 done one cycle", bit_done, 0);
  endtask

  task automatic run_dropped(input int op);
    int bad = 0;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = 1'b0;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 2'd0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_oe !== 1'b0 || sda_oe !== 1'b0 || bit_done !== 1'b0 || cmd_ready !== 1'b1) bad++;
    end
    chk(bad == 0, "R10 command on free bus dropped", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(scl_oe === 1'b0, "R1 scl_oe reset", scl_oe, 0);
    chk(sda_oe === 1'b0, "R1 sda_oe reset", sda_oe, 0);
    chk(bit_done === 1'b0, "R1 bit_done reset", bit_done, 0);
    chk(cmd_ready === 1'b1, "R1 cmd_ready reset", cmd_ready, 1);

    run_dropped(3);
    run_dropped(2);

    cur_hi = 3; cur_lo = 12; cur_code = 0;
    run_cmd(1, 0, "R2");
    run_cmd(3, 0, "R3");
    run_cmd(3, 1, "R3");
    run_cmd(1, 0, "R7");
    run_cmd(3, 0, "R3");
    run_cmd(1, 0, "R7");
    run_cmd(2, 0, "R6");
    run_dropped(3);

    cur_hi = 4; cur_lo = 20;
    run_cmd(1, 0, "R2");
    for (int c = 0; c < 4; c++) begin
      cur_code = c;
      run_cmd(3, c[0], "R4 code");
    end
    cur_lo = 5; cur_code = 3;
    run_cmd(3, 0, "R4 clamp");
    cur_hi = 0; cur_lo = 0; cur_code = 2;
    run_cmd(3, 1, "R8 zero");
    cur_lo = 1;
    run_cmd(1, 0, "R8 R7");
    cur_hi = 255; cur_lo = 255; cur_code = 3;
    run_cmd(3, 0, "R8 max");
    cur_hi = 2; cur_lo = 9; cur_code = 1;
    run_cmd(2, 0, "R6");

    for (int s = 0; s < 25; s++) begin
      tick_mode = int'($urandom % 2);
      scramble = 1;
      cur_hi = int'($urandom % 31); cur_lo = int'($urandom % 31);
      cur_code = int'($urandom % 4);
      run_cmd(1, 0, "R2");
      for (int k = 0; k < 1 + int'($urandom % 5); k++)
        run_cmd(3, 1'($urandom), "R3");
      if ($urandom % 2) begin
        run_cmd(1, 0, "R7");
        run_cmd(3, 1'($urandom), "R3");
      end
      run_cmd(2, 0, "R6");
      if ((s % 6) == 0) run_dropped(3);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule